// File: doc/BRIEF.md
# Operand Address Generation Sequencer

This block sits after instruction decode in a small 8-bit processor with a 16-bit address space. Once the decoder has named an addressing mode and pulsed `start`, the sequencer pulls the operand bytes that follow the opcode from a byte-wide fetch port. It forms the effective address and runs the data-memory read and/or write cycles the mode needs. When it finishes it raises a one-cycle `done` pulse together with the number of cycles it spent.

Four modes are handled:
- Index plus 16-bit offset.
- Stack pointer plus 16-bit offset. This form carries a prefix byte and so spends one extra cycle.
- Direct-page to direct-page move.
- Constant to direct-page move.

The direct page is addresses 0x0000 to 0x00FF. A direct address is the operand byte with zeros above it. The base register (stack pointer or index) is captured when the operation is accepted.

Top module: `opnd_addr_seq`

## Requirements
- R1: After reset and whenever idle, `busy`, `done`, `fetch_ack`, `mem_re` and `mem_we` are all low.
- R2: Mode 1 (stack form) takes the first fetched byte as the offset high byte and the second as the low byte. It reads memory once at stack pointer plus offset, and presents that byte on `operand` and that address on `eff_addr`.
- R3: Mode 1 reports 4 cycles on `cycles`. Mode 0 (index form: same byte order, base taken from `ix`) reports 3 cycles. The measured latency from the accepting edge to `done` equals the reported count.
- R4: Mode 2 reads once from address {0x00, first byte}, then writes that same byte to {0x00, second byte}. It takes 4 cycles, with read and write never in the same cycle.
- R5: Mode 3 writes the first fetched byte to {0x00, second byte} with no memory read, in 3 cycles.
- R6: The sum of base and offset wraps modulo 65536.
- R7: `start` is ignored while `busy` is high. A second `start` during an operation fetches no extra bytes and does not restart it.
- R8: `done` is a single-cycle pulse, high only when `busy` is low. Every operation consumes exactly two fetched bytes, acknowledged on `fetch_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | 0 index+offset, 1 stack+offset, 2 direct move, 3 constant move |
| sp | input | 16 | Current stack pointer |
| ix | input | 16 | Current index register |
| fetch_data | input | 8 | Next instruction-stream byte |
| fetch_ack | output | 1 | Byte on `fetch_data` consumed at this edge |
| mem_addr | output | 16 | Data memory address |
| mem_re | output | 1 | Read strobe; `mem_rdata` sampled this cycle |
| mem_rdata | input | 8 | Read data (valid in the strobe cycle) |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| operand | output | 8 | Byte read by an offset-mode operation |
| eff_addr | output | 16 | Effective address (destination for moves) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 3 | Cycle count of the completed operation |

## Verification
A wrong state in the sequencer shows up at the ports within one operation. A skipped or extra state changes the `cycles` value and the measured start-to-done latency at once. It also changes how many fetch acknowledges occur. A wrong latched byte shows as a bad address on the read or write strobe, or a bad written value. Those appear in the memory model and in `eff_addr` by the `done` pulse. The sweep covers base and offset values at both ends of the range and past the wrap. It also covers move pairs including source equal to destination, so a carry or byte-order error is caught in its first affected operation.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {
    MODE_IX16 = 2'd0,
    MODE_SP16 = 2'd1,
    MODE_MVDD = 2'd2,
    MODE_MVID = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_OPA  = 3'd2,
    ST_OPB  = 3'd3,
    ST_RD   = 3'd4,
    ST_WR   = 3'd5
  } state_e;
endpackage

// File: rtl/opnd_seq_fsm.sv
module opnd_seq_fsm
  import opnd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode,
  output state_e     state,
  output mode_e      mode_q,
  output logic       accept,
  output logic       last
);
  state_e nxt;

  assign accept = (state == ST_IDLE) && start;
  assign last   = ((state == ST_RD) && (mode_q != MODE_MVDD)) || (state == ST_WR);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = (mode_e'(mode) == MODE_SP16) ? ST_PRE : ST_OPA;
      ST_PRE:  nxt = ST_OPA;
      ST_OPA:  nxt = ST_OPB;
      ST_OPB:  nxt = (mode_q == MODE_MVID) ? ST_WR : ST_RD;
      ST_RD:   nxt = (mode_q == MODE_MVDD) ? ST_WR : ST_IDLE;
      ST_WR:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= MODE_IX16;
    end else begin
      state <= nxt;
      if (accept) mode_q <= mode_e'(mode);
    end
  end
endmodule

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic          direct,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] page_a
);
  localparam int PADW = AW - DW;
  logic [AW-1:0] offset;

  assign offset = AW'({hi, lo});
  assign page_a = {{PADW{1'b0}}, hi};
  // modulo-2^AW sum: the carry out is simply dropped
  assign ea = direct ? {{PADW{1'b0}}, lo} : (base + offset);
endmodule

// File: rtl/opnd_cycle_ctr.sv
module opnd_cycle_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          last,
  output logic [CW-1:0] total
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      total <= '0;
    end else begin
      if (clr)     cnt <= '0;
      else if (en) cnt <= cnt + CW'(1);
      if (last)    total <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opnd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] ix,
  input  logic [DW-1:0] fetch_data,
  output logic          fetch_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] operand,
  output logic [AW-1:0] eff_addr,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cycles
);
  state_e        state;
  mode_e         mode_q;
  logic          accept, last;
  logic [AW-1:0] base_q, ea_q, ea_calc, src_addr;
  logic [DW-1:0] byte_a_q, data_q, operand_q;
  logic          done_q, is_move;

  opnd_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .state(state), .mode_q(mode_q), .accept(accept), .last(last)
  );

  assign is_move = (mode_q == MODE_MVDD) || (mode_q == MODE_MVID);

  opnd_addr_calc #(.AW(AW), .DW(DW)) u_calc (
    .base(base_q), .hi(byte_a_q), .lo(fetch_data), .direct(is_move),
    .ea(ea_calc), .page_a(src_addr)
  );

  opnd_cycle_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .clr(accept), .en(busy), .last(last), .total(cycles)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      byte_a_q  <= '0;
      data_q    <= '0;
      ea_q      <= '0;
      operand_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) base_q <= (mode_e'(mode) == MODE_SP16) ? sp : ix;
      case (state)
        ST_OPA: byte_a_q <= fetch_data;
        ST_OPB: ea_q     <= ea_calc;
        ST_RD: begin
          data_q <= mem_rdata;
          if (!is_move) operand_q <= mem_rdata;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign fetch_ack = (state == ST_OPA) || (state == ST_OPB);
  assign mem_re    = (state == ST_RD);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = ((state == ST_RD) && (mode_q == MODE_MVDD)) ? src_addr : ea_q;
  assign mem_wdata = (mode_q == MODE_MVID) ? byte_a_q : data_q;
  assign operand   = operand_q;
  assign eff_addr  = ea_q;
endmodule

// File: rtl/opnd_addr_seq_chk.sv
module opnd_addr_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          fetch_ack,
  input logic          mem_re,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic [CW-1:0] cycles
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!fetch_ack && !mem_re && !mem_we));
  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
  // R4
  dd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_re)) |-> (mem_wdata == $past(mem_rdata)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3
  cycle_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == CW'(3) || cycles == CW'(4)));
endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .fetch_ack(fetch_ack),
  .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata),
  .mem_wdata(mem_wdata), .cycles(cycles)
);

// File: tb/opnd_addr_seq_test.sv
module opnd_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] sp = '0, ix = '0;
  logic [7:0]  fetch_data;
  logic        fetch_ack, mem_re, mem_we, busy, done;
  logic [15:0] mem_addr, eff_addr;
  logic [7:0]  mem_rdata, mem_wdata, operand;
  logic [2:0]  cycles;

  int total = 0, bad = 0, ticks = 0;
  int ptr = 0, ptr0 = 0, rd_cnt = 0, wr_cnt = 0;
  logic [15:0] last_rd, last_wr;
  logic [7:0]  stream [0:1];
  logic [7:0]  mem [0:65535];

  always #2 clk = ~clk;

  opnd_addr_seq uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sp(sp), .ix(ix),
    .fetch_data(fetch_data), .fetch_ack(fetch_ack), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .operand(operand), .eff_addr(eff_addr),
    .busy(busy), .done(done), .cycles(cycles)
  );

  assign fetch_data = ((ptr - ptr0) >= 0 && (ptr - ptr0) < 2) ? stream[ptr - ptr0] : 8'h00;
  assign mem_rdata  = mem[mem_addr];

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (!rst) begin
      if (fetch_ack) ptr <= ptr + 1;
      if (mem_re) begin rd_cnt <= rd_cnt + 1; last_rd <= mem_addr; end
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1; last_wr <= mem_addr; mem[mem_addr] <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // launches one op, optional stray start in cycle 2; returns latency in edges
  task automatic launch(input logic [1:0] m, input logic [15:0] s, input logic [15:0] x,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input bit stray, output int lat);
    @(negedge clk);
    ptr0 = ptr; stream[0] = b0; stream[1] = b1;
    mode = m; sp = s; ix = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    if (stray) begin
      mode = 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat++;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    sp = 16'h5A5A; ix = 16'hA5A5;
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    chk(done == 1'b0, req, done, 0);
    chk(busy == 1'b0, req, busy, 0);
  endtask

  task automatic offset_op(input logic [1:0] m, input logic [15:0] base, input logic [15:0] off);
    int lat, rd0, wr0, n;
    logic [15:0] ea;
    logic [7:0]  val;
    ea  = base + off;
    val = mem[ea];
    n   = (m == 2'd1) ? 4 : 3;
    rd0 = rd_cnt; wr0 = wr_cnt;
    launch(m, (m == 2'd1) ? base : 16'hDEAD, (m == 2'd1) ? 16'hBEEF : base,
           off[15:8], off[7:0], 1'b0, lat);
    chk(done == 1'b1, "R8 done", done, 1);
    chk(eff_addr == ea, "R2 R6 ea", eff_addr, ea);
    chk(operand == val, "R2 operand", operand, val);
    chk(cycles == 3'(n), "R3 cycles", cycles, n);
    chk(lat - 1 == n, "R3 latency", lat - 1, n);
    chk(rd_cnt - rd0 == 1 && last_rd == ea, "R2 one read", last_rd, ea);
    chk(wr_cnt == wr0, "R2 no write", wr_cnt - wr0, 0);
    chk(ptr - ptr0 == 2, "R8 fetch count", ptr - ptr0, 2);
    after_done("R8 pulse");
  endtask

  task automatic move_op(input bit imm, input logic [7:0] b0, input logic [7:0] dst,
                         input bit stray);
    int lat, rd0, wr0, n;
    logic [7:0] val;
    val = imm ? b0 : mem[{8'h00, b0}];
    n   = imm ? 3 : 4;
    rd0 = rd_cnt; wr0 = wr_cnt;
    launch(imm ? 2'd3 : 2'd2, 16'h0, 16'h0, b0, dst, stray, lat);
    chk(mem[{8'h00, dst}] == val, imm ? "R5 data" : "R4 data", mem[{8'h00, dst}], val);
    chk(last_wr == {8'h00, dst} && wr_cnt - wr0 == 1, imm ? "R5 write" : "R4 write",
        last_wr, {8'h00, dst});
    if (imm) chk(rd_cnt == rd0, "R5 no read", rd_cnt - rd0, 0);
    else     chk(rd_cnt - rd0 == 1 && last_rd == {8'h00, b0}, "R4 read", last_rd, {8'h00, b0});
    chk(eff_addr == {8'h00, dst}, "R4 R5 ea", eff_addr, {8'h00, dst});
    chk(cycles == 3'(n), imm ? "R5 cycles" : "R4 cycles", cycles, n);
    chk(lat - 1 == n, stray ? "R7 latency" : "R4 R5 latency", lat - 1, n);
    chk(ptr - ptr0 == 2, stray ? "R7 fetch count" : "R8 fetch count", ptr - ptr0, 2);
    after_done(stray ? "R7 no restart" : "R8 pulse");
    if (stray) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && ptr - ptr0 == 2, "R7 stays idle", busy, 0);
    end
  endtask

  initial begin
    logic [15:0] bases [0:5];
    logic [15:0] offs  [0:5];
    bases = '{16'h0000, 16'h0001, 16'h00FF, 16'h7FFF, 16'hFFFF, 16'h1234};
    offs  = '{16'h0000, 16'h0001, 16'h00FF, 16'h8000, 16'hFFFF, 16'hABCD};
    for (int i = 0; i < 65536; i++) mem[i] = 8'((i * 7) ^ (i >> 8) ^ 8'h3C);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fetch_ack && !mem_re && !mem_we, "R1 reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !fetch_ack && !mem_re && !mem_we, "R1 idle", busy, 0);
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 6; b++)
        for (int o = 0; o < 6; o++)
          offset_op(2'(m), bases[b], offs[o]);
    for (int k = 0; k < 8; k++) begin
      move_op(1'b0, 8'(k * 37 + 5), 8'(k * 53 + 200), 1'b0);
      move_op(1'b1, 8'(k * 91 + 1), 8'(k * 29 + 7), 1'b0);
    end
    move_op(1'b0, 8'h44, 8'h44, 1'b0);
    move_op(1'b0, 8'hFF, 8'h00, 1'b0);
    move_op(1'b1, 8'hFF, 8'hFF, 1'b0);
    move_op(1'b1, 8'h6E, 8'h21, 1'b1);
    move_op(1'b0, 8'h12, 8'h34, 1'b1);
    finish_up();
  end

  initial begin
    wait (ticks > 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
    finish_up();
  end
endmodule